// File: doc/BRIEF.md
# Alternating-Slot Management Command Responder

This block is the hardware end of a management command channel on which only one command is ever outstanding. Software writes a command (a verb byte and a pool byte) into a single command register. The verb's top bit is a phase bit. The block treats the register as a new command only when that phase bit equals the phase it expects next. It then executes the command against a set of modelled buffer pools and posts the result into one of two response slots. Successive commands use the two slots in turn.

A response slot that has not been written for the current round reads back an all-zero verb, including its top bit. Software polls the expected slot until the verb becomes nonzero, and needs no busy flag. Each pool is a small first-in first-out store of buffer addresses. A release port fills it. An acquire command drains it into the response payload, and a query command reports how many buffers it holds. Software chooses the order of requests and handles timeouts. The block only guarantees that the completion of each command is visible in the right slot.

Top module: `mgmt_cmd_responder`

## Requirements
- R1: After reset both response slots read verb 0x00 and pool byte 0x00. With the reset phase parameter at 1 (the default), the first accepted command must carry phase 0 and its response appears in slot 0. With the parameter at 0, the first command must carry phase 1 and its response appears in slot 1.
- R2: A command whose verb bit 7 differs from the expected phase is ignored. No slot changes, and the previous response stays readable.
- R3: Each completed command toggles both the response slot and the expected phase, so consecutive responses alternate between slot 0 and slot 1.
- R4: The slot that the next command will use reads verb 0x00 from the moment the previous command completes until its own command completes. At most one slot holds a nonzero verb at any time.
- R5: An acquire has verb bits 6:4 = 001 and bits 3:0 = count (1 to 8). It completes with verb 0x90 | returned. Payload entries 0 to returned-1 hold the buffers in the order they were released. The response pool byte echoes the command's pool byte.
- R6: An acquire asking for more buffers than the pool holds returns only the ones held. An empty pool gives verb 0x90.
- R7: A query has verb bits 6:4 = 100 (bits 3:0 are ignored). It completes with verb 0xC0 | the pool's buffer count and leaves the pool unchanged.
- R8: These cases complete with verb 0xE0 and leave every pool unchanged: any other command code, an acquire count of 0 or above 8, or a pool byte of 64 or more.
- R9: The command check bit gives even parity over the verb, the pool byte and the check bit itself. A mismatch completes with verb 0xF0 and leaves every pool unchanged.
- R10: A release pulse appends the buffer to the named pool. A release to a pool already holding DEPTH (8) buffers, or to a pool byte of 64 or more, is dropped.
- R11: Only one command executes at a time. A command register write during execution does not disturb it. If the written phase matches the next expected phase, that command starts after the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_verb | input | 8 | Command verb: phase, code, count |
| cmd_pool | input | 8 | Pool index byte |
| cmd_chk | input | 1 | Even-parity check bit for verb and pool |
| rel_valid | input | 1 | Release one buffer into a pool |
| rel_pool | input | 8 | Pool index of the release |
| rel_buf | input | BUF_W | Buffer address released |
| rsp_sel | input | 1 | Response slot to read |
| rsp_idx | input | 3 | Payload entry to read |
| rsp_verb | output | 8 | Verb of the selected slot, 0x00 when not written |
| rsp_pool | output | 8 | Pool byte of the selected slot |
| rsp_buf | output | BUF_W | Selected payload entry |

## Verification
The assertions assume that software writes the command register with a phase that toggles once per command, and never writes a new expected-phase command before the previous one has been started. They also assume acquire counts stay within the 4-bit field. The bench keeps to these rules. It tracks the expected phase and slot itself, and it waits for each nonzero response verb before it issues the next command. The two deliberate exceptions are a stale-phase write and a single write placed while an eight-buffer acquire is still popping. Both are legal in the protocol, and the assertions cover them.

// File: rtl/mgmt_cmd_responder.sv
`timescale 1ns/1ps
module mgmt_cmd_responder #(
  parameter int POOLS = 64,
  parameter int DEPTH = 8,
  parameter int BUF_W = 16,
  parameter bit INIT_PHASE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_verb,
  input  logic [7:0]       cmd_pool,
  input  logic             cmd_chk,
  input  logic             rel_valid,
  input  logic [7:0]       rel_pool,
  input  logic [BUF_W-1:0] rel_buf,
  input  logic             rsp_sel,
  input  logic [2:0]       rsp_idx,
  output logic [7:0]       rsp_verb,
  output logic [7:0]       rsp_pool,
  output logic [BUF_W-1:0] rsp_buf
);
  localparam int PW = (POOLS > 1) ? $clog2(POOLS) : 1;
  localparam int DW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SLOT_BUFS = 8;

  typedef enum logic [1:0] {K_ACQ, K_QRY, K_INV, K_ECC} kind_t;

  logic [7:0]       cmd_verb_q, cmd_pool_q;
  logic             cmd_chk_q;
  logic             exp_ph, slot, busy;
  kind_t            w_kind, dec_kind;
  logic [3:0]       w_want, w_got;
  logic [PW-1:0]    w_pool;
  logic [7:0]       w_pbyte;
  logic [1:0]       slot_vld;
  logic [7:0]       slot_verb [2];
  logic [7:0]       slot_pool [2];
  logic [BUF_W-1:0] slot_buf  [2][SLOT_BUFS];
  logic [BUF_W-1:0] mem [POOLS][DEPTH];
  logic [DW-1:0]    rp  [POOLS];
  logic [DW-1:0]    wp  [POOLS];
  logic [CW-1:0]    cnt [POOLS];
  logic [7:0]       fin_verb;
  logic [3:0]       qcnt;

  function automatic logic [DW-1:0] step(input logic [DW-1:0] a);
    return (a == DW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  wire            par_ok  = ~^{cmd_verb_q, cmd_pool_q, cmd_chk_q};
  wire            pool_ok = int'(cmd_pool_q) < POOLS;
  wire            start   = !busy && (cmd_verb_q[7] == exp_ph);
  wire [PW-1:0]   rel_idx = rel_pool[PW-1:0];
  wire            push    = rel_valid && (int'(rel_pool) < POOLS) && (int'(cnt[rel_idx]) != DEPTH);
  wire [CW-1:0]   cur_cnt = cnt[w_pool];
  wire            pop     = busy && (w_kind == K_ACQ) && (w_got < w_want) && (cur_cnt != '0);
  wire            done    = busy && !pop;

  always_comb begin
    if (!par_ok)                       dec_kind = K_ECC;
    else if (!pool_ok)                 dec_kind = K_INV;
    else if (cmd_verb_q[6:4] == 3'b001 && cmd_verb_q[3:0] != 4'd0 && cmd_verb_q[3:0] <= 4'd8)
                                       dec_kind = K_ACQ;
    else if (cmd_verb_q[6:4] == 3'b100) dec_kind = K_QRY;
    else                               dec_kind = K_INV;
  end

  assign qcnt = (int'(cur_cnt) > 15) ? 4'd15 : 4'(cur_cnt);

  always_comb begin
    case (w_kind)
      K_ACQ:   fin_verb = {4'h9, w_got};
      K_QRY:   fin_verb = {4'hC, qcnt};
      K_INV:   fin_verb = 8'hE0;
      default: fin_verb = 8'hF0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_verb_q <= {INIT_PHASE, 7'd0};
      cmd_pool_q <= '0;
      cmd_chk_q  <= 1'b0;
      exp_ph     <= ~INIT_PHASE;
      slot       <= ~INIT_PHASE;
      busy       <= 1'b0;
      w_kind     <= K_INV;
      w_want     <= '0;
      w_got      <= '0;
      w_pool     <= '0;
      w_pbyte    <= '0;
      slot_vld   <= '0;
      slot_verb  <= '{default: '0};
      slot_pool  <= '{default: '0};
      rp         <= '{default: '0};
      wp         <= '{default: '0};
      cnt        <= '{default: '0};
    end else begin
      if (cmd_wr) begin
        cmd_verb_q <= cmd_verb;
        cmd_pool_q <= cmd_pool;
        cmd_chk_q  <= cmd_chk;
      end
      if (start) begin
        busy    <= 1'b1;
        w_kind  <= dec_kind;
        w_want  <= (dec_kind == K_ACQ) ? cmd_verb_q[3:0] : 4'd0;
        w_got   <= '0;
        w_pool  <= cmd_pool_q[PW-1:0];
        w_pbyte <= cmd_pool_q;
      end
      if (pop) w_got <= w_got + 4'd1;
      if (done) begin
        busy            <= 1'b0;
        slot_vld[slot]  <= 1'b1;
        slot_vld[~slot] <= 1'b0;
        slot_verb[slot] <= fin_verb;
        slot_pool[slot] <= w_pbyte;
        slot            <= ~slot;
        exp_ph          <= ~exp_ph;
      end
      for (int p = 0; p < POOLS; p++) begin
        if (push && rel_idx == PW'(p)) wp[p] <= step(wp[p]);
        if (pop && w_pool == PW'(p))   rp[p] <= step(rp[p]);
        cnt[p] <= cnt[p] + CW'(push && rel_idx == PW'(p)) - CW'(pop && w_pool == PW'(p));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[rel_idx][wp[rel_idx]] <= rel_buf;
    if (pop)  slot_buf[slot][w_got[2:0]] <= mem[w_pool][rp[w_pool]];
  end

  assign rsp_verb = slot_vld[rsp_sel] ? slot_verb[rsp_sel] : 8'h00;
  assign rsp_pool = slot_vld[rsp_sel] ? slot_pool[rsp_sel] : 8'h00;
  assign rsp_buf  = slot_buf[rsp_sel][rsp_idx];
endmodule

// File: rtl/mgmt_cmd_responder_chk.sv
`timescale 1ns/1ps
module mgmt_cmd_responder_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          slot,
  input logic          exp_ph,
  input logic          cmd_phase,
  input logic [1:0]    slot_vld,
  input logic [1:0]    w_kind,
  input logic [3:0]    w_got,
  input logic [3:0]    w_want,
  input logic [PW-1:0] w_pool
);
  a_r2_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_phase) == $past(exp_ph));

  a_r3_slot_flip: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> slot != $past(slot));

  a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> exp_ph != $past(exp_ph));

  a_r4_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_vld[0] && slot_vld[1]));

  a_r4_target_blank: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !slot_vld[slot]);

  a_r6_got_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> w_got <= w_want);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && $stable(w_pool) && $stable(w_kind) && $stable(slot));
endmodule

bind mgmt_cmd_responder mgmt_cmd_responder_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .slot(slot),
  .exp_ph(exp_ph), .cmd_phase(cmd_verb_q[7]), .slot_vld(slot_vld),
  .w_kind(w_kind), .w_got(w_got), .w_want(w_want), .w_pool(w_pool)
);

// File: tb/mgmt_cmd_responder_tb_top.sv
`timescale 1ns/1ps
module mgmt_cmd_responder_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, cmd_chk = 0, rel_valid = 0, rsp_sel = 0;
  logic [7:0]  cmd_verb = 0, cmd_pool = 0, rel_pool = 0;
  logic [15:0] rel_buf = 0;
  logic [2:0]  rsp_idx = 0;
  logic [7:0]  rsp_verb, rsp_pool;
  logic [15:0] rsp_buf;

  int checks = 0, errors = 0;
  logic ph = 1'b0, sl = 1'b0;
  logic [15:0] mq [64][$];
  logic [15:0] eb [8];

  always #10 clk = ~clk;

  mgmt_cmd_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_verb(cmd_verb), .cmd_pool(cmd_pool),
    .cmd_chk(cmd_chk), .rel_valid(rel_valid), .rel_pool(rel_pool), .rel_buf(rel_buf),
    .rsp_sel(rsp_sel), .rsp_idx(rsp_idx), .rsp_verb(rsp_verb), .rsp_pool(rsp_pool),
    .rsp_buf(rsp_buf)
  );

  // code|count without phase, pool
  localparam logic [15:0] VEC [12] = '{
    {8'h12, 8'd3},  {8'h40, 8'd3},  {8'h15, 8'd3},  {8'h11, 8'd3},
    {8'h18, 8'd10}, {8'h47, 8'd10}, {8'h21, 8'd0},  {8'h10, 8'd63},
    {8'h19, 8'd63}, {8'h11, 8'd64}, {8'h40, 8'd63}, {8'h12, 8'd63}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic release_buf(input logic [7:0] p, input logic [15:0] b);
    @(negedge clk);
    rel_valid = 1; rel_pool = p; rel_buf = b;
    @(negedge clk);
    rel_valid = 0;
    if (p < 64 && mq[p].size() < 8) mq[p].push_back(b);
  endtask

  task automatic write_cmd(input logic [7:0] v, input logic [7:0] p, input bit bad);
    @(negedge clk);
    cmd_wr = 1; cmd_verb = v; cmd_pool = p; cmd_chk = (^{v, p}) ^ bad;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  function automatic logic [7:0] model(input logic [7:0] v, input logic [7:0] p, input bit bad, output int k);
    k = 0;
    if (bad) return 8'hF0;
    if (p >= 64) return 8'hE0;
    if (v[6:4] == 3'b001 && v[3:0] >= 1 && v[3:0] <= 8) begin
      while (k < int'(v[3:0]) && mq[p].size() > 0) begin
        eb[k] = mq[p].pop_front();
        k++;
      end
      return 8'h90 | 8'(k);
    end
    if (v[6:4] == 3'b100) return 8'hC0 | 8'(mq[p].size());
    return 8'hE0;
  endfunction

  task automatic poll(input logic s, input string req);
    int n = 0;
    rsp_sel = s; rsp_idx = 0;
    #1;
    while (rsp_verb == 8'h00 && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk(n < 40, req, n, 40);
  endtask

  task automatic run_cmd(input logic [7:0] v, input logic [7:0] p, input bit bad, input string req);
    int k;
    logic [7:0] ev;
    ev = model(v, p, bad, k);
    write_cmd({ph, v[6:0]}, p, bad);
    rsp_sel = sl; #1;
    chk(rsp_verb == 8'h00, "R4 target blank before completion", rsp_verb, 0);
    poll(sl, "R3 response in expected slot");
    chk(rsp_verb == ev, req, rsp_verb, ev);
    chk(rsp_pool == p, "R5 pool byte echo", rsp_pool, p);
    for (int i = 0; i < k; i++) begin
      rsp_idx = 3'(i); #1;
      chk(rsp_buf == eb[i], "R5 payload order", rsp_buf, eb[i]);
    end
    rsp_sel = ~sl; #1;
    chk(rsp_verb == 8'h00, "R4 other slot blank", rsp_verb, 0);
    ph = ~ph; sl = ~sl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rsp_sel = 0; #1;
    chk(rsp_verb == 0 && rsp_pool == 0, "R1 slot0 reset", {rsp_verb, rsp_pool}, 0);
    rsp_sel = 1; #1;
    chk(rsp_verb == 0 && rsp_pool == 0, "R1 slot1 reset", {rsp_verb, rsp_pool}, 0);

    for (int i = 0; i < 5; i++) release_buf(8'd3, 16'h0300 + 16'(i));
    for (int i = 0; i < 9; i++) release_buf(8'd10, 16'h0A00 + 16'(i));
    release_buf(8'd63, 16'h3F00);
    release_buf(8'd63, 16'h3F01);
    release_buf(8'd70, 16'h4600);

    // first command: phase 0, slot 0 (R1)
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = VEC[i][15:8];
      run_cmd(v, VEC[i][7:0], 1'b0,
        (v[6:4] == 3'b100) ? "R7 query count" :
        (v[6:4] != 3'b001 || VEC[i][7:0] >= 64 || v[3:0] == 0 || v[3:0] > 8) ? "R8 invalid" :
        "R5 R6 R10 acquire result");
    end

    // R2: stale phase write ignored
    write_cmd({~ph, 7'h40}, 8'd3, 1'b0);
    repeat (10) @(negedge clk);
    rsp_sel = sl; #1;
    chk(rsp_verb == 8'h00, "R2 stale phase ignored", rsp_verb, 0);
    rsp_sel = ~sl; #1;
    chk(rsp_verb == 8'h92, "R2 previous result kept", rsp_verb, 8'h92);

    // R9: parity error, pool untouched
    for (int i = 0; i < 8; i++) release_buf(8'd20, 16'h1400 + 16'(i));
    run_cmd(8'h18, 8'd20, 1'b1, "R9 parity error");
    run_cmd(8'h40, 8'd20, 1'b0, "R9 pool untouched");
    run_cmd(8'h40, 8'd70, 1'b0, "R8 R10 bad pool");

    // R11: write during execution
    begin
      logic [7:0] e1, e2;
      int k;
      e1 = model(8'h18, 8'd20, 1'b0, k);
      e2 = model(8'h40, 8'd20, 1'b0, k);
      write_cmd({ph, 7'h18}, 8'd20, 1'b0);
      write_cmd({~ph, 7'h40}, 8'd20, 1'b0);
      poll(sl, "R11 first response");
      chk(rsp_verb == e1, "R11 first command intact", rsp_verb, e1);
      poll(~sl, "R11 queued response");
      chk(rsp_verb == e2, "R11 queued command result", rsp_verb, e2);
      rsp_sel = sl; #1;
      chk(rsp_verb == 8'h00, "R4 earlier slot cleared", rsp_verb, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule